// File: doc/BRIEF.md
# Half-Word Partial-Product Multiplier Array

This block computes the partial products of a 256 × 256-bit unsigned multiplication. Both operands are split into sixteen 16-bit halves. Sixteen multiply-accumulate cells then run in parallel over a fixed 16-cycle schedule. In each cycle every cell multiplies one half of the first operand by the half of the second operand that is shared in that cycle. The half of the first operand rotates from cell to cell.

The result is 31 wide partial words, numbered 0 to 30. Word k has weight 2^(16k), and their weighted sum equals the full product. Words 30 down to 16 leave the block one per cycle while the schedule runs. Words 0 to 15 appear together on a wide output bus at the end of the schedule. Carry resolution into a 512-bit product and modular reduction are handled by downstream blocks.

A single start pulse latches both operands and clears every accumulator. The caller then collects the streamed words and the final bus.

Top module: `halfword_mac_array`

## Requirements
- R1: After reset, `busy`, `drain_valid` and `done` are low and `low_words` is all zeros.
- R2: A start pulse accepted while idle latches `op_a` and `op_b`. Changes on those inputs afterwards have no effect on the results of that run.
- R3: Half index h of an operand covers bits [16h+15:16h]. In 32-bit word w, the low half is index 2w and the high half is index 2w+1.
- R4: Exactly 15 `drain_valid` pulses follow an accepted start, on consecutive cycles 2 to 16 after the start edge. `drain_idx` runs 30, 29, …, 16, falling by one each cycle.
- R5: Every word the block delivers, with index k, equals the sum of a_h[i]·b_h[j] over all pairs of half indices with i + j = k.
- R6: `done` is high for exactly one cycle, 17 cycles after the start edge. At that time slot w of `low_words` (bits [36w+35:36w]) holds partial word w, for w = 0..15.
- R7: The 31 partial words, each weighted by 2^(16k), sum to exactly op_a · op_b.
- R8: A start pulse while `busy` is high is ignored. The run in progress completes with its original operands and timing.
- R9: No accumulator ever exceeds 16·(2^16 − 1)², including when both operands are all ones, so the 36-bit words never wrap.
- R10: `low_words` keeps its value from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| op_a | input | 256 | First operand, eight 32-bit words, word 0 least significant |
| op_b | input | 256 | Second operand, same layout |
| busy | output | 1 | High from the start edge until `done` |
| drain_valid | output | 1 | A streamed partial word is present |
| drain_idx | output | 5 | Index of the streamed partial word |
| drain_word | output | 36 | Value of the streamed partial word |
| done | output | 1 | One-cycle pulse, `low_words` updated |
| low_words | output | 576 | Partial words 0..15, 36 bits each |

## Verification
An accumulator that is cleared at the wrong time, or a rotation of the operand index that is off by one, gives a wrong streamed word at the cycle when that cell drains. The error therefore shows up within 16 cycles, and the lower words show it at `done`. Each delivered word is compared with its convolution of halves, so the cycle of the first bad word points to the faulty cell. The weighted sum of all words is also compared with the true product, which catches a word placed at the wrong weight. Operands with a single non-zero half expose errors in the half split, and all-ones operands drive every cell to its largest value.

// File: rtl/hwmac_pkg.sv
package hwmac_pkg;
    localparam int DEF_WORD_W  = 32;
    localparam int DEF_NWORDS  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_t;

    function automatic int clog2i(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // (t - x) mod n for non-negative t, x below n
    function automatic int rot_index(input int t, input int x, input int n);
        return (t + n - x) % n;
    endfunction
endpackage

// File: rtl/operand_halves.sv
module operand_halves #(
    parameter int WORD_W = hwmac_pkg::DEF_WORD_W,
    parameter int NWORDS = hwmac_pkg::DEF_NWORDS,
    localparam int HALF_W = WORD_W / 2,
    localparam int NH     = 2 * NWORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NWORDS*WORD_W-1:0] op,
    output logic [HALF_W-1:0]        halves [NH]
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                halves[2*w]   <= '0;
                halves[2*w+1] <= '0;
            end else if (load) begin
                halves[2*w]   <= op[w*WORD_W          +: HALF_W];
                halves[2*w+1] <= op[w*WORD_W + HALF_W +: HALF_W];
            end
        end
    end
endmodule

// File: rtl/mac_cell.sv
module mac_cell #(
    parameter int HALF_W = 16,
    parameter int NH     = 16,
    localparam int PROD_W = 2 * HALF_W,
    localparam int ACC_W  = PROD_W + hwmac_pkg::clog2i(NH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              acc_en,
    input  logic              drop_old,
    input  logic [HALF_W-1:0] a_h,
    input  logic [HALF_W-1:0] b_h,
    output logic [ACC_W-1:0]  acc
);
    localparam longint HMAX  = (longint'(1) << HALF_W) - 1;
    localparam logic [ACC_W-1:0] BOUND = ACC_W'(longint'(NH) * HMAX * HMAX);

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  base;

    always_comb begin
        prod = a_h * b_h;
        base = drop_old ? '0 : acc;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) acc <= '0;
        else if (acc_en)    acc <= base + ACC_W'(prod);
    end

    // R9: the accumulator stays inside the 16-product bound
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> (acc <= BOUND));
endmodule

// File: rtl/run_sequencer.sv
module run_sequencer #(
    parameter int NH = 16,
    localparam int IDX_W = hwmac_pkg::clog2i(NH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             run,
    output logic             fin,
    output logic             busy,
    output logic [IDX_W-1:0] step
);
    import hwmac_pkg::*;
    phase_t phase;

    always_comb begin
        load = start && (phase == PH_IDLE);
        run  = (phase == PH_RUN);
        fin  = (phase == PH_FIN);
        busy = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_RUN;
                    step  <= '0;
                end
                PH_RUN: begin
                    step <= step + 1'b1;
                    if (step == IDX_W'(NH - 1)) phase <= PH_FIN;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: a start seen in the middle of a run does not restart the step count
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (run && step != IDX_W'(NH - 1)) |=> (run && step == $past(step) + 1'b1));
endmodule

// File: rtl/halfword_mac_array.sv
module halfword_mac_array #(
    parameter int WORD_W = hwmac_pkg::DEF_WORD_W,
    parameter int NWORDS = hwmac_pkg::DEF_NWORDS,
    localparam int HALF_W = WORD_W / 2,
    localparam int NH     = 2 * NWORDS,
    localparam int IDX_W  = hwmac_pkg::clog2i(NH),
    localparam int ACC_W  = 2 * HALF_W + IDX_W,
    localparam int NSI    = 2 * NH - 1,
    localparam int SI_W   = hwmac_pkg::clog2i(NSI)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [NWORDS*WORD_W-1:0] op_a,
    input  logic [NWORDS*WORD_W-1:0] op_b,
    output logic                     busy,
    output logic                     drain_valid,
    output logic [SI_W-1:0]          drain_idx,
    output logic [ACC_W-1:0]         drain_word,
    output logic                     done,
    output logic [NH*ACC_W-1:0]      low_words
);
    logic             load, run, fin;
    logic [IDX_W-1:0] step;
    logic [HALF_W-1:0] a_h [NH];
    logic [HALF_W-1:0] b_h [NH];
    logic [ACC_W-1:0]  acc [NH];
    logic [HALF_W-1:0] b_now;

    run_sequencer #(.NH(NH)) u_seq (
        .clk(clk), .rst(rst), .start(start), .load(load), .run(run),
        .fin(fin), .busy(busy), .step(step)
    );

    operand_halves #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_half_a (
        .clk(clk), .rst(rst), .load(load), .op(op_a), .halves(a_h)
    );
    operand_halves #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_half_b (
        .clk(clk), .rst(rst), .load(load), .op(op_b), .halves(b_h)
    );

    // shared b half descends with the step
    always_comb b_now = b_h[IDX_W'(NH - 1) - step];

    for (genvar x = 0; x < NH; x++) begin : g_cell
        logic [IDX_W-1:0] a_sel;
        logic             drop;
        always_comb begin
            a_sel = IDX_W'(hwmac_pkg::rot_index(int'(step), x, NH));
            drop  = (x != 0) && (step == IDX_W'(x));
        end
        mac_cell #(.HALF_W(HALF_W), .NH(NH)) u_cell (
            .clk(clk), .rst(rst), .clr_all(load), .acc_en(run),
            .drop_old(drop), .a_h(a_h[a_sel]), .b_h(b_now), .acc(acc[x])
        );
    end

    // stream out the upper words while the schedule runs
    always_ff @(posedge clk) begin
        if (rst) begin
            drain_valid <= 1'b0;
            drain_idx   <= '0;
            drain_word  <= '0;
        end else begin
            drain_valid <= run && (step != '0);
            if (run && (step != '0)) begin
                drain_idx  <= SI_W'(NSI) - SI_W'(step);
                drain_word <= acc[step];
            end
        end
    end

    // bulk write of the lower words after the final step
    for (genvar w = 0; w < NH; w++) begin : g_low
        always_ff @(posedge clk) begin
            if (rst)      low_words[w*ACC_W +: ACC_W] <= '0;
            else if (fin) low_words[w*ACC_W +: ACC_W] <= acc[NH-1-w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= fin;
    end

    // R4: streamed words come only during a run
    assert_drain_in_run_R4: assert property (@(posedge clk) disable iff (rst)
        drain_valid |-> busy);
    // R4: indices fall by one on back-to-back words
    assert_drain_desc_R4: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && $past(drain_valid)) |-> (drain_idx == $past(drain_idx) - 1'b1));
    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: lower words only change with done
    assert_low_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(low_words));
endmodule

// File: tb/sim_halfword_mac_array.sv
module sim_halfword_mac_array;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [255:0]  op_a = '0, op_b = '0;
    logic          busy, drain_valid, done;
    logic [4:0]    drain_idx;
    logic [35:0]   drain_word;
    logic [575:0]  low_words;

    int checks = 0;
    int failures = 0;
    logic [255:0] ref_a, ref_b;
    logic [35:0]  got [31];

    always #10 clk = ~clk;

    halfword_mac_array u0 (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .drain_valid(drain_valid), .drain_idx(drain_idx),
        .drain_word(drain_word), .done(done), .low_words(low_words)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5/R3: convolution of 16-bit halves, half h at bits [16h+15:16h]
    function automatic logic [35:0] exp_si(input int k);
        logic [35:0] s;
        s = '0;
        for (int i = 0; i < 16; i++) begin
            int j;
            j = k - i;
            if (j >= 0 && j < 16)
                s += 36'(ref_a[16*i +: 16]) * 36'(ref_b[16*j +: 16]);
        end
        return s;
    endfunction

    // one full run; disturb=1 changes inputs and pulses start mid-run (R2, R8)
    task automatic run_case(input logic [255:0] a, input logic [255:0] b,
                            input bit disturb, input string name);
        logic [639:0] tot;
        int ndrain;
        ref_a = a; ref_b = b; ndrain = 0;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (disturb && c == 4) begin
                op_a = ~a; op_b = a ^ b; start = 1'b1;
            end
            // R4: drains on cycles 2..16, index 32-c
            chk({"R4 drain_valid ", name}, 64'(drain_valid), 64'(c >= 2 && c <= 16));
            if (drain_valid) begin
                ndrain++;
                chk({"R4 drain_idx ", name}, 64'(drain_idx), 64'(32 - c));
                got[drain_idx] = drain_word;
                chk({"R5 drain_word ", name}, 64'(drain_word), 64'(exp_si(int'(drain_idx))));
            end
            // R6: done exactly at cycle 17
            chk({"R6 done ", name}, 64'(done), 64'(c == 17));
            if (c == 17) begin
                for (int w = 0; w < 16; w++) begin
                    got[w] = low_words[36*w +: 36];
                    chk({"R6 low word ", name}, 64'(got[w]), 64'(exp_si(w)));
                end
            end
        end
        chk({"R4 drain count ", name}, 64'(ndrain), 64'd15);
        tot = '0;
        for (int k = 0; k < 31; k++) tot += 640'(got[k]) << (16 * k);
        checks++;
        if (tot !== 640'(512'(a) * 512'(b))) begin
            failures++;
            $display("FAIL R7 product %s actual=%0h expected=%0h", name, tot, 512'(a) * 512'(b));
        end
    endtask

    // R10: low words hold after done when inputs move and no start comes
    task automatic hold_case();
        logic [575:0] snap;
        snap = low_words;
        @(negedge clk);
        op_a = {8{32'hDEAD_BEEF}}; op_b = '1;
        repeat (5) @(negedge clk);
        checks++;
        if (low_words !== snap) begin
            failures++;
            $display("FAIL R10 low_words actual=%0h expected=%0h", low_words, snap);
        end
        chk("R10 idle busy", 64'(busy), 64'd0);
    endtask

    task automatic reset_case();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 drain_valid", 64'(drain_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 low_words", 64'(low_words == '0), 64'd1);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        reset_case();
        run_case(256'd1, 256'd1, 1'b0, "unit");
        // R3: single high half of word 3 in a, low half of word 5 in b
        run_case(256'h1234 << (16 * 7), 256'hABCD << (16 * 10), 1'b0, "R3 halves");
        // R9: all-ones operands reach the per-cell maximum
        run_case('1, '1, 1'b0, "R9 all ones");
        run_case({8{32'h0F1E_2D3C}}, {4{64'h0123_4567_89AB_CDEF}}, 1'b0, "pattern");
        run_case({128'hFFFF_0000_A5A5_5A5A_8000_0001_7FFF_FFFE, 128'h3}, 256'hC0FFEE << 200,
                 1'b0, "sparse");
        // R2 and R8: mid-run start and input changes are ignored
        run_case({8{32'h9E37_79B9}}, {8{32'h7F4A_7C15}}, 1'b1, "R2 R8 disturb");
        hold_case();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule